// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This controller gathers up to fifteen interrupt request lines and hands the most urgent one to a processor. Two identical eight-line priority units are used. The second unit does not take a line of its own in the first unit's order. Its combined request enters the first unit on that unit's line 2, so lines 8 to 15 share the priority position of line 2. When a request is pending and is not blocked by work already in service, a single interrupt output rises. The processor answers with an acknowledge pulse, and one cycle later the controller presents an 8-bit vector for the winning line.

Each accepted line is kept in an in-service set until an end-of-interrupt strobe names that line. A strictly more urgent request may interrupt the service of a less urgent one. Requests of the same or lower urgency wait. Older software drives the line that the cascade occupies, so an option steers such a request to line 9. Each unit has its own vector base.

Top module: `casc_irq_ctrl`

## Requirements
- R1: While reset is low, `int_o` and `vec_valid_o` are 0.
- R2: A rising edge on a request line is latched as pending, and `int_o` is 1 in the cycle after the clock edge that captured it, provided nothing of equal or higher urgency is in service.
- R3: Within a unit, a lower line index is more urgent. For first-unit line n, the vector is `pri_base_i` + n.
- R4: Lines 8..15 take the urgency slot of line 2. Line 1 beats line 9, and line 9 beats line 3. For line 8+k, the vector is `sec_base_i` + k.
- R5: A rising edge of `inta_i` sampled while `int_o` is 1 is an acknowledge. In the following cycle, `vec_valid_o` is 1 for exactly one cycle with the vector on `vec_o`. The acknowledged line leaves pending and enters service.
- R6: While a line is in service, a pending request of equal or lower urgency keeps `int_o` at 0. A strictly more urgent request raises `int_o`.
- R7: `eoi_i` with `eoi_line_i` = L removes line L from service, and a request that was held back can then raise `int_o`.
- R8: When `remap_en_i` is 1, a rising edge on `req_i[2]` acts as line 9 (vector `sec_base_i` + 1). When it is 0, `req_i[2]` has no effect.
- R9: While a second-unit line is in service, a more urgent second-unit line still raises `int_o` through the cascade slot.
- R10: The cascade slot stays in service until the last second-unit line in service receives its end-of-interrupt. Until then, lines 3..7 stay held.
- R11: An `inta_i` rising edge while `int_o` is 0 produces no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| req_i | input | 16 | Request lines 0..15; bit 2 is used only through the remap option |
| remap_en_i | input | 1 | Steers `req_i[2]` to line 9 |
| pri_base_i | input | 8 | Vector base for lines 0..7 |
| sec_base_i | input | 8 | Vector base for lines 8..15 |
| inta_i | input | 1 | Acknowledge from the processor; its rising edge is used |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_line_i | input | 4 | Line number that the end-of-interrupt strobe releases |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle qualifier for `vec_o` |
| vec_o | output | 8 | Vector of the acknowledged line |

## Verification
The acknowledge commit and the capture of a new request edge can land on the same clock edge. The bench provokes this by raising line 0 in the same cycle that it pulses the acknowledge for a pending line 6. The scoreboard must then receive line 6's vector, because the new edge was not yet pending when the acknowledge was resolved. Immediately afterwards `int_o` must be 1, because line 0 now pre-empts line 6 in service. A second acknowledge must return line 0's vector.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int UNIT_LINES = 8;
  localparam int IDX_W      = $clog2(UNIT_LINES);
  localparam int LINE_W     = IDX_W + 1;
  localparam int CASC_LINE  = 2;
  localparam int REMAP_SLOT = 1;
  localparam int VEC_W      = 8;
endpackage

// File: rtl/cirq_prio.sv
module cirq_prio #(
  parameter int N = cirq_pkg::UNIT_LINES,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/cirq_unit.sv
module cirq_unit #(
  parameter int N        = cirq_pkg::UNIT_LINES,
  parameter bit HAS_CASC = 1'b0,
  parameter int CASC_IDX = cirq_pkg::CASC_LINE,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          casc_req_i,
  input  logic          take_i,
  input  logic          eoi_i,
  input  logic [IW-1:0] eoi_idx_i,
  output logic          int_o,
  output logic [IW-1:0] win_o,
  output logic [N-1:0]  isr_o
);
  localparam logic [IW-1:0] CASC_SEL = IW'(CASC_IDX);
  localparam logic [N-1:0]  ONE      = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  req_q, pend_q, isr_q;
  logic [N-1:0]  pend_n, isr_n, rise, eff_pend, take_mask, eoi_mask;
  logic          pend_en, isr_en;
  logic          p_any, s_any;
  logic [IW-1:0] p_idx, s_idx;

  // next-state logic
  always_comb begin
    rise      = req_i & ~req_q;
    eff_pend  = pend_q;
    if (HAS_CASC) eff_pend[CASC_IDX] = casc_req_i;
    take_mask = take_i ? (ONE << p_idx) : '0;
    eoi_mask  = eoi_i ? (ONE << eoi_idx_i) : '0;
    pend_n    = (pend_q & ~take_mask) | rise;
    if (HAS_CASC) pend_n[CASC_IDX] = 1'b0;
    isr_n     = (isr_q | take_mask) & ~eoi_mask;
    pend_en   = (|rise) | take_i;
    isr_en    = take_i | eoi_i;
  end

  cirq_prio #(.N(N)) u_pend_prio (.vec_i(eff_pend), .any_o(p_any), .idx_o(p_idx));
  cirq_prio #(.N(N)) u_isr_prio  (.vec_i(isr_q),    .any_o(s_any), .idx_o(s_idx));

  // nesting rule: strictly more urgent, or the cascade slot (already nested below)
  always_comb begin
    int_o = p_any && (!s_any || (p_idx < s_idx) ||
            (HAS_CASC && (p_idx == s_idx) && (p_idx == CASC_SEL)));
  end

  assign win_o = p_idx;
  assign isr_o = isr_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      req_q <= req_i;
      if (pend_en) pend_q <= pend_n;
      if (isr_en)  isr_q  <= isr_n;
    end
  end
endmodule

// File: rtl/cirq_ack.sv
module cirq_ack #(
  parameter int IW       = cirq_pkg::IDX_W,
  parameter int VW       = cirq_pkg::VEC_W,
  parameter int CASC_IDX = cirq_pkg::CASC_LINE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inta_i,
  input  logic          int_i,
  input  logic [IW-1:0] pri_win_i,
  input  logic [IW-1:0] sec_win_i,
  input  logic [VW-1:0] pri_base_i,
  input  logic [VW-1:0] sec_base_i,
  output logic          ack_o,
  output logic          vec_valid_o,
  output logic [VW-1:0] vec_o
);
  logic          inta_q, vld_q;
  logic [VW-1:0] vec_q, vec_n;

  always_comb begin
    ack_o = inta_i & ~inta_q & int_i;
    if (pri_win_i == IW'(CASC_IDX)) vec_n = sec_base_i + VW'(sec_win_i);
    else                            vec_n = pri_base_i + VW'(pri_win_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q <= 1'b0;
      vld_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      inta_q <= inta_i;
      vld_q  <= ack_o;
      if (ack_o) vec_q <= vec_n;
    end
  end

  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
  parameter int N  = cirq_pkg::UNIT_LINES,
  parameter int VW = cirq_pkg::VEC_W,
  localparam int IW = $clog2(N),
  localparam int LW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*N-1:0] req_i,
  input  logic          remap_en_i,
  input  logic [VW-1:0] pri_base_i,
  input  logic [VW-1:0] sec_base_i,
  input  logic          inta_i,
  input  logic          eoi_i,
  input  logic [LW-1:0] eoi_line_i,
  output logic          int_o,
  output logic          vec_valid_o,
  output logic [VW-1:0] vec_o
);
  localparam int CASC  = cirq_pkg::CASC_LINE;
  localparam int RSLOT = cirq_pkg::REMAP_SLOT;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N-1:0]  pri_req, sec_req, sec_isr, pri_isr;
  logic          sec_int, pri_int, ack;
  logic [IW-1:0] pri_win, sec_win, eoi_k, pri_eoi_idx;
  logic          eoi_sec, sec_last, pri_eoi, sec_eoi, sec_take;

  // request steering
  always_comb begin
    pri_req       = req_i[N-1:0];
    pri_req[CASC] = 1'b0;
    sec_req       = req_i[2*N-1:N];
    sec_req[RSLOT] = sec_req[RSLOT] | (remap_en_i & req_i[CASC]);
  end

  // end-of-interrupt routing
  always_comb begin
    eoi_sec     = eoi_line_i[LW-1];
    eoi_k       = eoi_line_i[IW-1:0];
    sec_last    = ((sec_isr & ~(ONE << eoi_k)) == '0);
    sec_eoi     = eoi_i & eoi_sec;
    pri_eoi     = eoi_i & (eoi_sec ? sec_last : (eoi_k != IW'(CASC)));
    pri_eoi_idx = eoi_sec ? IW'(CASC) : eoi_k;
    sec_take    = ack & (pri_win == IW'(CASC));
  end

  cirq_unit #(.N(N), .HAS_CASC(1'b0), .CASC_IDX(CASC)) u_sec (
    .clk(clk), .rst_n(rst_int_n), .req_i(sec_req), .casc_req_i(1'b0),
    .take_i(sec_take), .eoi_i(sec_eoi), .eoi_idx_i(eoi_k),
    .int_o(sec_int), .win_o(sec_win), .isr_o(sec_isr)
  );

  cirq_unit #(.N(N), .HAS_CASC(1'b1), .CASC_IDX(CASC)) u_pri (
    .clk(clk), .rst_n(rst_int_n), .req_i(pri_req), .casc_req_i(sec_int),
    .take_i(ack), .eoi_i(pri_eoi), .eoi_idx_i(pri_eoi_idx),
    .int_o(pri_int), .win_o(pri_win), .isr_o(pri_isr)
  );

  cirq_ack #(.IW(IW), .VW(VW), .CASC_IDX(CASC)) u_ack (
    .clk(clk), .rst_n(rst_int_n), .inta_i(inta_i), .int_i(pri_int),
    .pri_win_i(pri_win), .sec_win_i(sec_win),
    .pri_base_i(pri_base_i), .sec_base_i(sec_base_i),
    .ack_o(ack), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  assign int_o = pri_int;
endmodule

// File: rtl/cirq_chk.sv
module cirq_chk (
  input logic clk,
  input logic rst_n,
  input logic inta_i,
  input logic int_o,
  input logic vec_valid_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!int_o && !vec_valid_o)
        else $error("R1 outputs active in reset");
    end
  end

  a_r5_ack_gives_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inta_i) && int_o) |=> vec_valid_o);

  a_r5_vector_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  a_r11_vector_needs_int: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(int_o));

  a_r11_vector_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(inta_i));
endmodule

bind casc_irq_ctrl cirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .int_o(int_o), .vec_valid_o(vec_valid_o)
);

// File: tb/tb_casc_irq_ctrl.sv
module tb_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] req_i = '0;
  logic        remap_en_i = 1'b0;
  logic [7:0]  pri_base_i = 8'h20;
  logic [7:0]  sec_base_i = 8'h70;
  logic        inta_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic [3:0]  eoi_line_i = '0;
  logic        int_o, vec_valid_o;
  logic [7:0]  vec_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  casc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .remap_en_i(remap_en_i),
    .pri_base_i(pri_base_i), .sec_base_i(sec_base_i), .inta_i(inta_i),
    .eoi_i(eoi_i), .eoi_line_i(eoi_line_i),
    .int_o(int_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected vectors as the design presents them
  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected vector actual %0h expected none", vec_o);
      end else begin
        chk("R3/R4 vector", vec_o, exp_q.pop_front());
      end
    end
  end

  task automatic raise(input logic [15:0] mask);
    @(negedge clk) req_i = mask;
    @(negedge clk) req_i = '0;
  endtask

  task automatic ack(input logic [7:0] exp);
    @(negedge clk);
    exp_q.push_back(exp);
    inta_i = 1'b1;
    @(negedge clk) inta_i = 1'b0;
    @(negedge clk) chk("R5 valid one cycle", {7'b0, vec_valid_o}, 8'd0);
  endtask

  task automatic eoi(input logic [3:0] line);
    @(negedge clk) begin eoi_i = 1'b1; eoi_line_i = line; end
    @(negedge clk) eoi_i = 1'b0;
  endtask

  task automatic chk_int(input string tag, input logic exp);
    chk(tag, {7'b0, int_o}, {7'b0, exp});
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_int("R1 int in reset", 1'b0);
    chk("R1 valid in reset", {7'b0, vec_valid_o}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_int("R1 int after reset", 1'b0);

    // R2, R3, R5
    raise(16'h0020);
    chk_int("R2 int on request", 1'b1);
    ack(8'h25);
    chk_int("R5 int drops after ack", 1'b0);
    eoi(4'd5);

    // R3 ordering, R6 lower held, R7 release
    raise(16'h0050);
    chk_int("R3 int", 1'b1);
    ack(8'h24);
    chk_int("R6 lower held", 1'b0);
    eoi(4'd4);
    chk_int("R7 released", 1'b1);
    ack(8'h26);
    eoi(4'd6);

    // R4 cascade slot, R9 secondary nesting, R10 cascade service
    raise(16'h020A);
    ack(8'h21);
    chk_int("R4 slot below line1", 1'b0);
    eoi(4'd1);
    chk_int("R4 line9 pending", 1'b1);
    ack(8'h71);
    chk_int("R10 line3 held", 1'b0);
    raise(16'h0100);
    chk_int("R9 line8 preempts 9", 1'b1);
    ack(8'h70);
    eoi(4'd8);
    chk_int("R10 still held", 1'b0);
    eoi(4'd9);
    chk_int("R10 released", 1'b1);
    ack(8'h23);
    eoi(4'd3);
    chk_int("R7 idle", 1'b0);

    // R6 equal held, more urgent preempts
    raise(16'h0020);
    ack(8'h25);
    raise(16'h0020);
    chk_int("R6 equal held", 1'b0);
    raise(16'h0001);
    chk_int("R6 preempt", 1'b1);
    ack(8'h20);
    eoi(4'd0);
    chk_int("R6 pending equal still held", 1'b0);
    eoi(4'd5);
    chk_int("R7 held line5 released", 1'b1);
    ack(8'h25);
    eoi(4'd5);

    // R8 remap
    raise(16'h0004);
    chk_int("R8 line2 ignored", 1'b0);
    remap_en_i = 1'b1;
    raise(16'h0004);
    chk_int("R8 remapped", 1'b1);
    ack(8'h71);
    eoi(4'd9);
    chk_int("R8 done", 1'b0);

    // R11 spurious acknowledge
    @(negedge clk) inta_i = 1'b1;
    @(negedge clk) inta_i = 1'b0;
    chk("R11 no vector", {7'b0, vec_valid_o}, 8'd0);

    // same-cycle acknowledge and new request edge
    raise(16'h0040);
    @(negedge clk);
    exp_q.push_back(8'h26);
    inta_i = 1'b1; req_i = 16'h0001;
    @(negedge clk) begin inta_i = 1'b0; req_i = '0; end
    chk_int("R6 line0 over line6 in service", 1'b1);
    ack(8'h20);
    eoi(4'd0);
    eoi(4'd6);

    // new bases
    pri_base_i = 8'h40; sec_base_i = 8'h90;
    raise(16'h0080);
    ack(8'h47);
    eoi(4'd7);
    raise(16'h8000);
    ack(8'h97);
    eoi(4'd15);
    chk_int("R7 final idle", 1'b0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R5: missing vectors actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule